// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block turns a one-cycle expiry event from a watchdog into a reset pulse on an external pin. The pulse length, its active level and the way the pin is driven are all set through one 32-bit configuration word. The low twenty bits hold a length in microseconds, counted with a 1 MHz strobe supplied from outside. The active level and the drive style change only when a write carries one of four key bytes in its top eight bits. Any other top byte leaves both settings alone, but the length field is still taken from the write.

The block drives a level and an output enable for a pad buffer. In push-pull mode the enable stays on all the time. In open-drain mode it is on only while the level is low, so the pin floats whenever it should read high. A second expiry event that arrives during a pulse starts the length count again from the beginning.

Top module: `xrst_pulse_gen`

## Requirements
- R1: After reset the configuration word reads 0x000000FF (length field 0xFF, active low, open drain), the pulse is inactive, `pulse_o` is 1 and `pulse_oe` is 0.
- R2: Every write loads bits 19:0 of the write data into the length field, whatever its top byte. Bits 29:20 always read as zero. The new value appears on `cfg_rdata` in the cycle after the write edge.
- R3: A write whose top byte (bits 31:24) is 0xA5 makes the pulse active high, and one whose top byte is 0x5A makes it active low. Bit 31 of `cfg_rdata` reads 1 when the pulse is active high.
- R4: A write whose top byte is 0xA8 selects push-pull drive, and one whose top byte is 0x8A selects open drain. Bit 30 of `cfg_rdata` reads 1 for push-pull.
- R5: A write whose top byte is none of 0xA5, 0x5A, 0xA8 or 0x8A leaves bits 31 and 30 unchanged.
- R6: A `fire` pulse starts the reset pulse at the next clock edge. With length field N the pulse ends at the edge of the (N+1)-th `tick_us` strobe sampled after the `fire` cycle. A strobe in the same cycle as `fire` is not counted.
- R7: A `fire` during a pulse restarts the count, so the pulse then lasts N+1 further strobes.
- R8: While the pulse is active `pulse_o` equals the active level (1 for active high). Otherwise it equals the opposite level.
- R9: `pulse_oe` is 1 at all times in push-pull mode. In open-drain mode it is 1 exactly when `pulse_o` is 0.
- R10: The length is captured when `fire` is sampled. A write during a pulse does not change the length of that pulse.
- R11: `tick_us` strobes while no pulse is active have no effect. A length field of 0 gives a pulse of exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data: key byte in bits 31:24, length in bits 19:0 |
| cfg_rdata | output | 32 | Read-back: level bit 31, drive bit 30, zeros, length |
| tick_us | input | 1 | One-cycle strobe at 1 MHz |
| fire | input | 1 | One-cycle watchdog expiry event |
| pulse_o | output | 1 | Level presented to the pad |
| pulse_oe | output | 1 | Output enable for the pad |

## Verification
The read-back, the pulse level and the enable all come straight from registers, so every result is due in the cycle after the edge that samples its stimulus. A write shows on `cfg_rdata` one edge later. A `fire` raises the pulse one edge later. The strobe that ends the pulse drops it at that same edge. A behavioural model in the bench updates at each rising edge from the inputs it sees. It is compared with all three outputs at the following falling edge, where inputs are also changed, so every check looks at settled values one cycle after the cause. Directed sequences count strobes until the pin returns to idle, to check the N+1 length, the restart and the capture of the length when `fire` is sampled.

// File: rtl/xrst_pkg.sv
`timescale 1ns/1ps
package xrst_pkg;
    localparam int unsigned CFG_W   = 32;
    localparam int unsigned KEY_W   = 8;
    localparam logic [KEY_W-1:0] KEY_LVL_HIGH = 8'hA5;
    localparam logic [KEY_W-1:0] KEY_LVL_LOW  = 8'h5A;
    localparam logic [KEY_W-1:0] KEY_PUSHPULL = 8'hA8;
    localparam logic [KEY_W-1:0] KEY_OPENDRN  = 8'h8A;

    typedef struct packed {
        logic act_high;
        logic push_pull;
    } drive_mode_t;
endpackage

// File: rtl/xrst_cfg_reg.sv
`timescale 1ns/1ps
module xrst_cfg_reg
    import xrst_pkg::*;
#(
    parameter int unsigned LEN_W   = 20,
    parameter logic [LEN_W-1:0] LEN_RST = 'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wr_data,
    output logic [LEN_W-1:0]    len_q_o,
    output drive_mode_t         mode_q_o,
    output logic [CFG_W-1:0]    rd_data
);
    localparam int unsigned PAD_W = CFG_W - 2 - LEN_W;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        drive_mode_t      mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [KEY_W-1:0] key_byte;

    assign key_byte = wr_data[CFG_W-1 -: KEY_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.len = wr_data[LEN_W-1:0];
            case (key_byte)
                KEY_LVL_HIGH: cfg_d.mode.act_high  = 1'b1;
                KEY_LVL_LOW:  cfg_d.mode.act_high  = 1'b0;
                KEY_PUSHPULL: cfg_d.mode.push_pull = 1'b1;
                KEY_OPENDRN:  cfg_d.mode.push_pull = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.len            <= LEN_RST;
            cfg_q.mode.act_high  <= 1'b0;
            cfg_q.mode.push_pull <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign len_q_o  = cfg_q.len;
    assign mode_q_o = cfg_q.mode;
    assign rd_data  = {cfg_q.mode.act_high, cfg_q.mode.push_pull, {PAD_W{1'b0}}, cfg_q.len};

    // R2: a write always lands in the length field
    assert_len_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> len_q_o == $past(wr_data[LEN_W-1:0]));
    // R3: level keys
    assert_level_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte == KEY_LVL_HIGH) |=> mode_q_o.act_high);
    // R4: drive keys
    assert_drive_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte == KEY_OPENDRN) |=> !mode_q_o.push_pull);
    // R5: a non-key byte keeps both mode bits
    assert_nokey_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_byte != KEY_LVL_HIGH && key_byte != KEY_LVL_LOW &&
         key_byte != KEY_PUSHPULL && key_byte != KEY_OPENDRN) |=> $stable(mode_q_o));
endmodule

// File: rtl/xrst_pulse_timer.sv
`timescale 1ns/1ps
module xrst_pulse_timer #(
    parameter int unsigned LEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             active_o
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] remain;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_last;

    assign at_last = (tmr_q.remain == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (fire) begin
            tmr_d.active = 1'b1;
            tmr_d.remain = len;
        end else if (tmr_q.active && tick) begin
            if (at_last) tmr_d.active = 1'b0;
            else         tmr_d.remain = tmr_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active_o = tmr_q.active;

    // R7: a trigger (re)loads the full length, R10: from the value seen at that edge
    assert_fire_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (tmr_q.active && tmr_q.remain == $past(len)));
    // R6: each strobe inside a pulse takes one step
    assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && tmr_q.active && tick && !at_last) |=> (tmr_q.active && tmr_q.remain == $past(tmr_q.remain) - 1'b1));
    // R6: the last strobe ends the pulse
    assert_tick_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && tmr_q.active && tick && at_last) |=> !tmr_q.active);
    // R11: without trigger or strobe nothing moves; idle strobes start nothing
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && (!tick || !tmr_q.active)) |=> $stable(tmr_q));
endmodule

// File: rtl/xrst_pad_drive.sv
`timescale 1ns/1ps
module xrst_pad_drive
    import xrst_pkg::*;
(
    input  logic        active,
    input  drive_mode_t mode,
    output logic        level_o,
    output logic        oe_o
);
    always_comb begin
        level_o = active ? mode.act_high : ~mode.act_high;
        oe_o    = mode.push_pull | ~level_o;
    end
endmodule

// File: rtl/xrst_pulse_gen.sv
`timescale 1ns/1ps
module xrst_pulse_gen
    import xrst_pkg::*;
#(
    parameter int unsigned LEN_W   = 20,
    parameter logic [LEN_W-1:0] LEN_RST = 'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             tick_us,
    input  logic             fire,
    output logic             pulse_o,
    output logic             pulse_oe
);
    logic [LEN_W-1:0] len_q;
    drive_mode_t      mode_q;
    logic             active;

    xrst_cfg_reg #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .len_q_o(len_q), .mode_q_o(mode_q), .rd_data(cfg_rdata)
    );

    xrst_pulse_timer #(.LEN_W(LEN_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .fire(fire), .tick(tick_us),
        .len(len_q), .active_o(active)
    );

    xrst_pad_drive u_pad (
        .active(active), .mode(mode_q), .level_o(pulse_o), .oe_o(pulse_oe)
    );

    // R9: the pin only floats while it should read high
    assert_float_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_oe |-> pulse_o);
    // R9: push-pull keeps the driver on
    assert_pp_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[CFG_W-2] |-> pulse_oe);
    // R8: a trigger makes the pin show the active level next cycle
    assert_fire_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cfg_we) |=> pulse_o == cfg_rdata[CFG_W-1]);
endmodule

// File: tb/tb_xrst_pulse_gen.sv
`timescale 1ns/1ps
module tb_xrst_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_us = 1'b0;
    logic        fire = 1'b0;
    logic        pulse_o, pulse_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xrst_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick_us(tick_us), .fire(fire),
        .pulse_o(pulse_o), .pulse_oe(pulse_oe)
    );

    // behavioural reference
    logic [19:0] m_len;
    bit          m_high, m_pp, m_on, m_ok = 1'b0;
    int          m_left;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_len = 20'hFF; m_high = 1'b0; m_pp = 1'b0; m_on = 1'b0; m_left = 0; m_ok = 1'b1;
        end else begin
            if (fire) begin
                m_on = 1'b1; m_left = int'(m_len);
            end else if (m_on && tick_us) begin
                if (m_left == 0) m_on = 1'b0;
                else m_left--;
            end
            if (cfg_we) begin
                m_len = cfg_wdata[19:0];
                if (cfg_wdata[31:24] == 8'hA5) m_high = 1'b1;
                if (cfg_wdata[31:24] == 8'h5A) m_high = 1'b0;
                if (cfg_wdata[31:24] == 8'hA8) m_pp = 1'b1;
                if (cfg_wdata[31:24] == 8'h8A) m_pp = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (m_ok && !done) begin
            logic lvl;
            lvl = m_on ? m_high : ~m_high;
            check("R2/R3/R4/R5 readback", cfg_rdata, {m_high, m_pp, 10'b0, m_len});
            check("R6/R8 pulse level", {31'b0, pulse_o}, {31'b0, lvl});
            check("R9 output enable", {31'b0, pulse_oe}, {31'b0, m_pp | ~lvl});
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic trig(input bit with_tick);
        @(negedge clk); fire = 1'b1; tick_us = with_tick;
        @(negedge clk); fire = 1'b0; tick_us = 1'b0;
    endtask

    task automatic tk(input int gap);
        for (int i = 0; i < gap; i++) @(negedge clk);
        tick_us = 1'b1;
        @(negedge clk); tick_us = 1'b0;
    endtask

    function automatic bit pin_active(input bit high);
        return pulse_o == high;
    endfunction

    task automatic measure(input bit high, output int n);
        n = 0;
        while (pin_active(high) && n < 100) begin
            tk(2);
            n++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        wait (cyc > 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset readback", cfg_rdata, 32'h0000_00FF);
        check("R1 reset level", {31'b0, pulse_o}, 32'd1);
        check("R1 reset enable", {31'b0, pulse_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: idle strobes change nothing
        tk(1); tk(1);
        check("R11 idle ticks", {31'b0, pulse_o}, 32'd1);

        // R2: non-key top byte, upper bits read zero
        wr(32'hFFFF_FFFF);
        check("R2 pad zero", cfg_rdata, 32'h000F_FFFF);
        // R5: non-key leaves mode
        wr(32'h1200_0007);
        check("R5 mode kept", cfg_rdata, 32'h0000_0007);

        // R6: length 3 gives four strobes, open drain active low
        wr(32'h0000_0003);
        trig(1'b1);
        check("R6 started", {31'b0, pulse_o}, 32'd0);
        measure(1'b0, n);
        check("R6 strobe count N=3", n, 4);

        // R11: length 0 gives one strobe
        wr(32'h0000_0000);
        trig(1'b0);
        measure(1'b0, n);
        check("R11 length zero", n, 1);

        // R7: restart mid pulse
        wr(32'h0000_0005);
        trig(1'b0);
        tk(1); tk(1); tk(1);
        trig(1'b0);
        measure(1'b0, n);
        check("R7 restart count", n, 6);

        // R10: write during pulse does not change it
        wr(32'h0000_0002);
        trig(1'b0);
        wr(32'h0000_0009);
        measure(1'b0, n);
        check("R10 captured length", n, 3);

        // R3: active high, still open drain
        wr(32'hA500_0001);
        check("R3 high readback", cfg_rdata, 32'h8000_0001);
        check("R9 od idle low driven", {31'b0, pulse_oe}, 32'd1);
        trig(1'b0);
        check("R8 active high level", {31'b0, pulse_o}, 32'd1);
        check("R9 od high floats", {31'b0, pulse_oe}, 32'd0);
        measure(1'b1, n);
        check("R6 count active high", n, 2);

        // R4: push-pull
        wr(32'hA800_0001);
        check("R4 pp readback", cfg_rdata, 32'hC000_0001);
        trig(1'b0);
        check("R9 pp driven", {31'b0, pulse_oe}, 32'd1);
        measure(1'b1, n);
        wr(32'h5A00_0004);
        check("R3 low readback", cfg_rdata, 32'h4000_0004);
        wr(32'h8A00_0004);
        check("R4 od readback", cfg_rdata, 32'h0000_0004);
        wr(32'h3300_0010);
        check("R5 no key", cfg_rdata, 32'h0000_0010);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule